// File: doc/BRIEF.md
# System Control Coprocessor: Status, Cause and Exception Entry

This block keeps the processor's system control state: a Status register holding a three-level stack of interrupt-enable and mode bits, a Cause register recording why the last exception was taken, and an exception return address register (EPC). The pipeline reads and writes these registers through a single indexed port, used by the move-to and move-from coprocessor instructions. Any index that is not one of the three dedicated registers is backed by a plain storage word.

The pipeline signals a syscall or break trap together with the PC of the trapping instruction and whether it sat in a branch delay slot. The block then pushes the enable/mode stack, records the exception code and the delay-slot flag, saves the return address, and one cycle later pulses a vector request carrying the handler address. A return-from-exception command pops the stack. A register write that leaves an enabled software interrupt pending raises an exception on the same clock edge. External interrupt lines are sampled into read-only Cause bits.

Top module: `cop0_ctrl`

## Requirements
- R1: After reset, Status reads 0x00400000, Cause and EPC read 0, the vector request output is low and the vector address is 0.
- R2: A write at Status (index 12) replaces all 32 bits. A write at EPC (index 14), or at any index other than 12 and 13, stores the value unchanged. Reads are combinational and return the stored value.
- R3: A write at Cause (index 13) changes only Cause bits 9..8. Every other Cause bit keeps its value.
- R4: A syscall trap sets the Cause code field (bits 6..2) to 8. A break trap sets it to 9. Cause bits outside 31, 15..10 and 6..2 keep their values.
- R5: On exception entry Status bits 5..0 become {old bits 3..0, 2'b00}, and Status bits 31..6 are unchanged.
- R6: On exception entry outside a delay slot, EPC gets the instruction PC and Cause bit 31 is cleared. Inside a delay slot, EPC gets the PC minus 4 and Cause bit 31 is set.
- R7: The vector request is high for exactly the one cycle after an exception entry. The vector address is 0x80000080, or 0xBFC00180 when Status bit 22 is set at entry.
- R8: Return-from-exception keeps Status bits 31..4 and loads bits 3..0 from the old bits 5..2.
- R9: When a write at Status or Cause leaves (Cause[9:8] & Status[9:8]) nonzero with Status bit 0 set, an exception is taken on the same edge with code field 0, using the written values as the base for R5 to R7.
- R10: At most one command acts per cycle, with priority trap request, then return-from-exception, then register write. A command of lower priority in the same cycle has no effect.
- R11: Cause bits 15..10 show the external pending inputs sampled on the previous clock edge. Register writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | IDX_W | Register index for read and write |
| reg_wr_en | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the indexed register |
| trap_req | input | 1 | Syscall or break trap request |
| trap_is_break | input | 1 | 1 selects break, 0 selects syscall |
| instr_pc | input | 32 | PC of the instruction that traps or writes |
| instr_in_delay | input | 1 | The instruction sits in a branch delay slot |
| rfe | input | 1 | Return-from-exception command |
| hw_pend | input | HW_IRQS | External interrupt pending lines |
| vec_valid | output | 1 | One-cycle vector request |
| vec_addr | output | 32 | Handler address of the latest exception |

## Verification
The bench builds the block with its default parameters: a 5-bit index and six pending lines. This keeps every register index within reach of a full write/read sweep. It also allows a walk over all 64 patterns of the six stack bits, each pushed by a trap and then popped. Every combination of written software-interrupt bits, mask bits and global enable is tried with both delay-slot settings, so each case that fires or stays quiet is observed at the vector outputs. Expected register contents come from an arithmetic model kept in the bench.

// File: rtl/cop0_pkg.sv
// Shared constants for the system control coprocessor.
// Assumes 32-bit registers; dedicated indices fixed by the instruction decoder.
package cop0_pkg;
    localparam int WORD_W      = 32;
    localparam int IDX_STATUS  = 12;
    localparam int IDX_CAUSE   = 13;
    localparam int IDX_EPC     = 14;
    localparam int BIT_BEV     = 22;
    localparam int BIT_IE      = 0;
    localparam logic [4:0]  CODE_SYSCALL = 5'd8;
    localparam logic [4:0]  CODE_BREAK   = 5'd9;
    localparam logic [4:0]  CODE_SOFTINT = 5'd0;
    localparam logic [31:0] VEC_RAM = 32'h8000_0080;
    localparam logic [31:0] VEC_ROM = 32'hBFC0_0180;

    // True for indices held by dedicated registers rather than the plain bank
    function automatic bit is_dedicated(input int idx);
        return (idx == IDX_STATUS) || (idx == IDX_CAUSE) || (idx == IDX_EPC);
    endfunction
endpackage

// File: rtl/cop0_gen_bank.sv
// Plain storage for every register index that has no dedicated function.
// Assumes the caller gates writes; dedicated slots are not built and read 0.
module cop0_gen_bank #(
    parameter int IDX_W = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    import cop0_pkg::*;

    logic [31:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (is_dedicated(i)) begin : g_none
            assign slot[i] = '0;
        end else begin : g_word
            // Store one word when its index is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot[i] <= '0;
                else if (wr_en && (idx == IDX_W'(i)))
                    slot[i] <= wdata;
            end
        end
    end

    assign rdata = slot[idx];
endmodule

// File: rtl/cop0_trap_arbiter.sv
// Picks the one command acting this cycle and decides whether an exception
// is entered, with its code and vector choice. Purely combinational.
// Assumes status/cause inputs are the registered values.
module cop0_trap_arbiter #(
    parameter int IDX_W = 5
) (
    input  logic             trap_req,
    input  logic             trap_is_break,
    input  logic             rfe,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [31:0]      status_q,
    input  logic [1:0]       cause_sw_q,
    output logic             do_wr,
    output logic             do_rfe,
    output logic             take_exc,
    output logic [4:0]       exc_code,
    output logic             vec_rom
);
    import cop0_pkg::*;

    localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] SEL_CAUSE  = IDX_W'(IDX_CAUSE);

    logic        wr_status, wr_cause, soft_hit;
    logic [31:0] status_after;
    logic [1:0]  sw_after;

    // Priority: trap, then return, then register write
    always_comb begin
        do_rfe = rfe && !trap_req;
        do_wr  = wr_en && !trap_req && !rfe;
    end

    // Software interrupt check on the values the write leaves behind
    always_comb begin
        wr_status    = do_wr && (wr_idx == SEL_STATUS);
        wr_cause     = do_wr && (wr_idx == SEL_CAUSE);
        status_after = wr_status ? wr_data : status_q;
        sw_after     = wr_cause ? wr_data[9:8] : cause_sw_q;
        soft_hit     = (wr_status || wr_cause) &&
                       ((sw_after & status_after[9:8]) != 2'b00) &&
                       status_after[BIT_IE];
    end

    // Exception decision, code and vector selection
    always_comb begin
        take_exc = trap_req || soft_hit;
        if (trap_req)
            exc_code = trap_is_break ? CODE_BREAK : CODE_SYSCALL;
        else
            exc_code = CODE_SOFTINT;
        vec_rom = status_after[BIT_BEV];
    end
endmodule

// File: rtl/cop0_sys_regs.sv
// Status, Cause and EPC registers with the enable/mode stack.
// Assumes at most one of write, return and exception is active unless the
// exception is a software interrupt raised by the write itself.
module cop0_sys_regs #(
    parameter int          IDX_W      = 5,
    parameter int          HW_IRQS    = 6,
    parameter logic [31:0] STATUS_RST = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_wr,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_data,
    input  logic               do_rfe,
    input  logic               take_exc,
    input  logic [4:0]         exc_code,
    input  logic [31:0]        instr_pc,
    input  logic               instr_in_delay,
    input  logic [HW_IRQS-1:0] hw_pend,
    output logic [31:0]        status_q,
    output logic [31:0]        cause_q,
    output logic [31:0]        epc_q
);
    import cop0_pkg::*;

    localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_STATUS);
    localparam logic [IDX_W-1:0] SEL_CAUSE  = IDX_W'(IDX_CAUSE);
    localparam logic [IDX_W-1:0] SEL_EPC    = IDX_W'(IDX_EPC);

    logic [31:0] status_d, cause_d, epc_d;

    // Next Status: write or pop, then push on exception entry
    always_comb begin
        status_d = status_q;
        if (do_wr && (wr_idx == SEL_STATUS))
            status_d = wr_data;
        if (do_rfe)
            status_d = {status_q[31:4], status_q[5:2]};
        if (take_exc)
            status_d = {status_d[31:6], status_d[3:0], 2'b00};
    end

    // Next Cause: software bits, exception record, pending lines
    always_comb begin
        cause_d = cause_q;
        if (do_wr && (wr_idx == SEL_CAUSE))
            cause_d[9:8] = wr_data[9:8];
        if (take_exc) begin
            cause_d[6:2] = exc_code;
            cause_d[31]  = instr_in_delay;
        end
        cause_d[10 +: HW_IRQS] = hw_pend;
    end

    // Next EPC: plain write or return address on exception entry
    always_comb begin
        epc_d = epc_q;
        if (do_wr && (wr_idx == SEL_EPC))
            epc_d = wr_data;
        if (take_exc)
            epc_d = instr_in_delay ? (instr_pc - 32'd4) : instr_pc;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            cause_q  <= '0;
            epc_q    <= '0;
        end else begin
            status_q <= status_d;
            cause_q  <= cause_d;
            epc_q    <= epc_d;
        end
    end
endmodule

// File: rtl/cop0_ctrl.sv
// Top of the system control coprocessor: register port, exception entry,
// return-from-exception and vector request.
// Assumes one trap/return/write command stream from the pipeline.
module cop0_ctrl #(
    parameter int          IDX_W      = 5,
    parameter int          HW_IRQS    = 6,
    parameter logic [31:0] STATUS_RST = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic               reg_wr_en,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               trap_req,
    input  logic               trap_is_break,
    input  logic [31:0]        instr_pc,
    input  logic               instr_in_delay,
    input  logic               rfe,
    input  logic [HW_IRQS-1:0] hw_pend,
    output logic               vec_valid,
    output logic [31:0]        vec_addr
);
    import cop0_pkg::*;

    logic        do_wr, do_rfe, take_exc, vec_rom;
    logic [4:0]  exc_code;
    logic [31:0] status_q, cause_q, epc_q, bank_rdata;

    cop0_trap_arbiter #(.IDX_W(IDX_W)) u_arb (
        .trap_req      (trap_req),
        .trap_is_break (trap_is_break),
        .rfe           (rfe),
        .wr_en         (reg_wr_en),
        .wr_idx        (reg_idx),
        .wr_data       (reg_wdata),
        .status_q      (status_q),
        .cause_sw_q    (cause_q[9:8]),
        .do_wr         (do_wr),
        .do_rfe        (do_rfe),
        .take_exc      (take_exc),
        .exc_code      (exc_code),
        .vec_rom       (vec_rom)
    );

    cop0_sys_regs #(
        .IDX_W      (IDX_W),
        .HW_IRQS    (HW_IRQS),
        .STATUS_RST (STATUS_RST)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .do_wr          (do_wr),
        .wr_idx         (reg_idx),
        .wr_data        (reg_wdata),
        .do_rfe         (do_rfe),
        .take_exc       (take_exc),
        .exc_code       (exc_code),
        .instr_pc       (instr_pc),
        .instr_in_delay (instr_in_delay),
        .hw_pend        (hw_pend),
        .status_q       (status_q),
        .cause_q        (cause_q),
        .epc_q          (epc_q)
    );

    cop0_gen_bank #(.IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (do_wr),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (bank_rdata)
    );

    // Read mux: dedicated registers first, plain bank otherwise
    always_comb begin
        if (reg_idx == IDX_W'(IDX_STATUS))
            reg_rdata = status_q;
        else if (reg_idx == IDX_W'(IDX_CAUSE))
            reg_rdata = cause_q;
        else if (reg_idx == IDX_W'(IDX_EPC))
            reg_rdata = epc_q;
        else
            reg_rdata = bank_rdata;
    end

    // Vector request pulse and held handler address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= take_exc;
            if (take_exc)
                vec_addr <= vec_rom ? VEC_ROM : VEC_RAM;
        end
    end
endmodule

// File: rtl/cop0_ctrl_chk.sv
// Temporal checks on the system control coprocessor, bound to its top.
// Assumes synchronous active-low reset.
module cop0_ctrl_chk #(
    parameter int HW_IRQS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_req,
    input logic               rfe,
    input logic               reg_wr_en,
    input logic [31:0]        instr_pc,
    input logic               instr_in_delay,
    input logic [HW_IRQS-1:0] hw_pend,
    input logic [31:0]        status_q,
    input logic [31:0]        cause_q,
    input logic [31:0]        epc_q,
    input logic               vec_valid,
    input logic [31:0]        vec_addr
);
    logic past_ok;

    // Marks cycles whose previous edge was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r7_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> vec_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !reg_wr_en) |=> !vec_valid);

    a_r7_vec_addr: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (vec_addr == ($past(status_q[22]) ? 32'hBFC0_0180 : 32'h8000_0080)));

    a_r5_push: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (status_q[5:0] == {$past(status_q[3:0]), 2'b00}) &&
                     (status_q[31:6] == $past(status_q[31:6])));

    a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !trap_req) |=> (status_q[3:0] == $past(status_q[5:2])) &&
                               (status_q[31:4] == $past(status_q[31:4])));

    a_r6_delay_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && instr_in_delay) |=> (epc_q == $past(instr_pc) - 32'd4) && cause_q[31]);

    a_r6_plain_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !instr_in_delay) |=> (epc_q == $past(instr_pc)) && !cause_q[31]);

    a_r3_cause_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !trap_req && !rfe) |=>
            (cause_q[30:16] == $past(cause_q[30:16])) && (cause_q[1:0] == $past(cause_q[1:0])) &&
            (cause_q[7] == $past(cause_q[7])));

    a_r11_hw_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cause_q[10 +: HW_IRQS] == $past(hw_pend)));
endmodule

bind cop0_ctrl cop0_ctrl_chk #(.HW_IRQS(HW_IRQS)) chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_req       (trap_req),
    .rfe            (rfe),
    .reg_wr_en      (reg_wr_en),
    .instr_pc       (instr_pc),
    .instr_in_delay (instr_in_delay),
    .hw_pend        (hw_pend),
    .status_q       (status_q),
    .cause_q        (cause_q),
    .epc_q          (epc_q),
    .vec_valid      (vec_valid),
    .vec_addr       (vec_addr)
);

// File: tb/cop0_ctrl_test.sv
module cop0_ctrl_test;
    localparam int IDX_W = 5;
    localparam int HW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic             reg_wr_en = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             trap_req = 1'b0;
    logic             trap_is_break = 1'b0;
    logic [31:0]      instr_pc = '0;
    logic             instr_in_delay = 1'b0;
    logic             rfe = 1'b0;
    logic [HW-1:0]    hw_pend = '0;
    logic             vec_valid;
    logic [31:0]      vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the architectural state
    logic [31:0] m_st, m_ca, m_ep, m_va;
    logic [31:0] m_gen [32];

    always #4 clk = ~clk;

    cop0_ctrl #(.IDX_W(IDX_W), .HW_IRQS(HW)) uut (
        .clk, .rst_n, .reg_idx, .reg_wr_en, .reg_wdata, .reg_rdata,
        .trap_req, .trap_is_break, .instr_pc, .instr_in_delay, .rfe,
        .hw_pend, .vec_valid, .vec_addr
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        reg_idx = IDX_W'(idx);
        #1;
        v = reg_rdata;
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] v;
        rd(12, v); chk({tag, " status"}, v, m_st);
        rd(13, v); chk({tag, " cause"},  v, m_ca);
        rd(14, v); chk({tag, " epc"},    v, m_ep);
    endtask

    // One command cycle; model computed from the requirements
    task automatic step(input bit w, input int idx, input logic [31:0] d,
                        input bit e, input bit brk, input bit r,
                        input logic [31:0] pc, input bit dly, input string tag);
        bit dw, dr, swi, tk;
        logic [31:0] st, ca, ep;
        logic [1:0] csw;
        dw  = w && !e && !r;                              // R10 priority
        dr  = r && !e;
        st  = m_st;
        if (dw && idx == 12) st = d;                      // R2
        if (dr) st = {m_st[31:4], m_st[5:2]};             // R8
        csw = (dw && idx == 13) ? d[9:8] : m_ca[9:8];     // R3
        swi = dw && (idx == 12 || idx == 13) && ((csw & st[9:8]) != 0) && st[0]; // R9
        tk  = e || swi;
        ca  = m_ca;
        ca[9:8] = csw;
        ep  = m_ep;
        if (dw && idx == 14) ep = d;
        if (tk) begin
            ca[6:2] = e ? (brk ? 5'd9 : 5'd8) : 5'd0;     // R4
            ca[31]  = dly;                                // R6
            ep      = dly ? pc - 32'd4 : pc;
            m_va    = st[22] ? 32'hBFC0_0180 : 32'h8000_0080; // R7
            st      = {st[31:6], st[3:0], 2'b00};         // R5
        end
        ca[15:10] = hw_pend;                              // R11
        if (dw && !(idx >= 12 && idx <= 14)) m_gen[idx] = d;

        @(negedge clk);
        reg_idx = IDX_W'(idx); reg_wr_en = w; reg_wdata = d;
        trap_req = e; trap_is_break = brk; rfe = r;
        instr_pc = pc; instr_in_delay = dly;
        @(negedge clk);
        reg_wr_en = 1'b0; trap_req = 1'b0; rfe = 1'b0;
        m_st = st; m_ca = ca; m_ep = ep;
        chk({tag, " R7 vec_valid"}, {31'b0, vec_valid}, {31'b0, tk});
        chk({tag, " R7 vec_addr"}, vec_addr, m_va);
        check_regs(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        for (int i = 0; i < 32; i++) m_gen[i] = '0;
        m_st = 32'h0040_0000; m_ca = '0; m_ep = '0; m_va = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_regs("R1 reset");
        chk("R1 vec_valid", {31'b0, vec_valid}, 32'd0);
        chk("R1 vec_addr", vec_addr, 32'd0);

        // R2 plain bank round trip over every index
        for (int i = 0; i < 32; i++)
            if (!(i >= 12 && i <= 14))
                step(1, i, 32'hA5A5_0000 ^ (i * 32'h0101_0101), 0, 0, 0, 0, 0, "R2 bank");
        for (int i = 0; i < 32; i++)
            if (!(i >= 12 && i <= 14)) begin
                rd(i, v); chk("R2 bank read", v, m_gen[i]);
            end
        step(1, 14, 32'h1234_5678, 0, 0, 0, 0, 0, "R2 epc write");
        step(1, 12, 32'hF0F0_F0C0, 0, 0, 0, 0, 0, "R2 status write");

        // R3 only software bits of Cause take a write
        step(1, 12, 32'h0, 0, 0, 0, 0, 0, "R3 status clear");
        step(1, 13, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R3 cause all ones");
        step(1, 13, 32'h0, 0, 0, 0, 0, 0, "R3 cause zero");

        // R4 R5 R6 R7 R8: push/pop over every 6-bit stack pattern
        for (int s = 0; s < 64; s++) begin
            step(1, 12, {9'b0, s[1], 16'b0, s[5:0]}, 0, 0, 0, 0, 0, "R5 status setup");
            step(0, 0, 0, 1, s[2], 0, 32'h0000_1000 + s * 4, s[0], "R4 R5 R6 trap");
            step(0, 0, 0, 0, 0, 1, 0, 0, "R8 return");
        end

        // R9 software interrupt sweep: sw bits x mask x enable x delay
        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 4; m++)
                for (int ie = 0; ie < 2; ie++)
                    for (int dl = 0; dl < 2; dl++) begin
                        step(1, 13, 32'h0, 0, 0, 0, 0, 0, "R9 cause clear");
                        step(1, 12, {22'b0, m[1:0], 7'b0, ie[0]}, 0, 0, 0, 0, 0, "R9 status");
                        step(1, 13, {22'b0, c[1:0], 8'b0}, 0, 0, 0, 32'h0000_2000 + c * 64, dl[0], "R9 cause");
                    end
        // R9 fired by a Status write with the software bits already set
        step(1, 12, 32'h0, 0, 0, 0, 0, 0, "R9 status off");
        step(1, 13, 32'h0000_0100, 0, 0, 0, 0, 0, "R9 arm cause");
        step(1, 12, 32'h0040_0101, 0, 0, 0, 32'h0000_3000, 0, "R9 status fires");

        // R10 priority: trap beats write, return beats write, trap beats return
        step(1, 12, 32'h0000_0015, 0, 0, 0, 0, 0, "R10 setup");
        step(1, 12, 32'hFFFF_FFFF, 1, 1, 0, 32'h0000_4000, 0, "R10 trap over write");
        step(1, 12, 32'hFFFF_FFFF, 0, 0, 1, 0, 0, "R10 return over write");
        step(0, 0, 0, 1, 0, 1, 32'h0000_4100, 1, "R10 trap over return");
        step(1, 5, 32'hDEAD_BEEF, 0, 0, 1, 0, 0, "R10 bank write ignored");
        rd(5, v); chk("R10 bank unchanged", v, m_gen[5]);

        // R11 pending lines mirrored and not writable
        step(1, 12, 32'h0, 0, 0, 0, 0, 0, "R11 status clear");
        hw_pend = 6'h2A;
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11 sample");
        step(1, 13, 32'h0000_0000, 0, 0, 0, 0, 0, "R11 write zero");
        hw_pend = 6'h15;
        step(1, 13, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R11 write ones");
        hw_pend = 6'h00;
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11 release");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule